// File: doc/BRIEF.md
# AXI Read Hang Tracer

This block sits passively beside the read half of an AXI port. It watches the read-address and read-data handshakes and keeps a small table of reads still waiting for their final data beat. For each one it runs an age counter that starts at the address handshake. The counter stops only when the last beat is actually accepted, so a slave that shows data the master never takes still counts as stalled. Each read that finishes goes into a short circular history, which replaces its oldest record once it is full. Nothing leaves the block during normal running.

When a tracked read reaches a programmable age limit, the block raises a single-cycle trigger and freezes the history. It then appends the stalled read as a final record and streams the history out, oldest first, over a valid/ready port. Each record holds the ID, address and measured latency of a read, so both the initiator and the target of a hang can be found. After the dump the block waits until software clears and sets its enable. Clearing the enable also discards the tracked reads and the history.

Top module: `axi_rd_hang_tracer`

## Requirements
- R1: While reset is asserted or enable is low, trc_valid and trigger stay 0, whatever happens on the bus. Monitoring starts on the second clock edge after enable rises.
- R2: A read is timed from the edge on which arvalid and arready are both high. It ends only on an edge with rvalid, rready and rlast all high and a matching rid. rvalid held without rready does not end it. A record's latency field counts the edges from the address edge to that final data edge, so a read answered on the next edge has latency 1.
- R3: While armed and before a trigger, trc_valid stays 0 however many reads complete.
- R4: trigger is high for exactly one cycle. That is the first cycle in which a tracked read's age, counted as edges since its address edge, reaches the threshold. Thresholds above 16384 act as 16384.
- R5: The dump starts on the cycle after the trigger. It delivers the retained completed reads oldest first and ends with the stalled read, whose hung flag is 1 and whose latency equals the effective threshold. The history keeps at most DEPTH records in all, including the stalled one, and older completions are overwritten.
- R6: Every record carries the read's ID and its address as captured at the address handshake.
- R7: At most SLOTS reads are tracked, and their IDs must differ. A read that arrives while the table is full, or whose ID is already tracked, is neither timed nor recorded.
- R8: If several reads expire, the one in the lowest table slot wins, and later expiries are ignored. Completions in the trigger cycle or after it are not recorded, and no second trigger fires before re-arming.
- R9: While trc_valid is high and trc_ready is low, the record on the output stays unchanged. A record is consumed on each edge with both high.
- R10: After the last record the block stays silent, even through new hangs, until enable goes low and high again. Re-arming clears the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms the monitor; low clears and idles it |
| threshold | input | CNT_W | Age limit in cycles, capped at MAX_TH |
| arvalid | input | 1 | Observed read-address valid |
| arready | input | 1 | Observed read-address ready |
| arid | input | ID_W | Observed read-address ID |
| araddr | input | ADDR_W | Observed read address |
| rvalid | input | 1 | Observed read-data valid |
| rready | input | 1 | Observed read-data ready |
| rid | input | ID_W | Observed read-data ID |
| rlast | input | 1 | Observed last-beat marker |
| trc_valid | output | 1 | Trace record available |
| trc_ready | input | 1 | Trace record accepted |
| trc_id | output | ID_W | Record: read ID |
| trc_addr | output | ADDR_W | Record: read address |
| trc_lat | output | CNT_W | Record: latency in cycles |
| trc_hung | output | 1 | Record: this is the stalled read (last record) |
| trigger | output | 1 | One-cycle pulse on threshold crossing |

## Verification
The bench builds the block with DEPTH of 4 and four table slots. An eight-read run therefore overwrites the history twice before the hang. Filling the table and adding a fifth read tests the untracked-read path with few transactions. The age counter keeps its default 15-bit width, and the limit stays at 16384. A threshold of 20000 therefore shows the clamp within about 16400 cycles. The other hangs use thresholds of 30 and 60, so the trigger cycle can be checked exactly.

// File: rtl/axi_rd_hang_tracer.sv
`timescale 1ns/1ps
module axi_rd_hang_tracer #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int SLOTS  = 4,
  parameter int CNT_W  = 15,
  parameter int MAX_TH = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              arvalid,
  input  logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              rvalid,
  input  logic              rready,
  input  logic [ID_W-1:0]   rid,
  input  logic              rlast,
  output logic              trc_valid,
  input  logic              trc_ready,
  output logic [ID_W-1:0]   trc_id,
  output logic [ADDR_W-1:0] trc_addr,
  output logic [CNT_W-1:0]  trc_lat,
  output logic              trc_hung,
  output logic              trigger
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] TH_CAP  = CNT_W'(MAX_TH);
  localparam logic [CNT_W-1:0] AGE_TOP = '1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_DUMP, S_DONE} st_t;
  st_t st;

  logic              sl_v    [SLOTS];
  logic [ID_W-1:0]   sl_id   [SLOTS];
  logic [ADDR_W-1:0] sl_addr [SLOTS];
  logic [CNT_W-1:0]  sl_age  [SLOTS];

  logic [ID_W-1:0]   rg_id   [DEPTH];
  logic [ADDR_W-1:0] rg_addr [DEPTH];
  logic [CNT_W-1:0]  rg_lat  [DEPTH];
  logic              rg_hung [DEPTH];

  logic [PW-1:0] wp, rp, rp_start, rp_inc, wp_inc;
  logic [CW-1:0] cnt, cnt_nx, left;

  logic ar_hs, r_end, armed, push, rec_push, alloc;
  logic ret_hit, hit, free_ok, dup;
  logic [SW-1:0] ret_idx, hit_idx, free_idx, w_idx;
  logic [CNT_W-1:0] thr_eff;

  assign ar_hs   = arvalid && arready;
  assign r_end   = rvalid && rready && rlast;
  assign thr_eff = (threshold > TH_CAP) ? TH_CAP : threshold;
  assign armed   = (st == S_ARMED) && enable;

  always_comb begin
    ret_hit = 1'b0; ret_idx = '0;
    hit = 1'b0;     hit_idx = '0;
    free_ok = 1'b0; free_idx = '0;
    dup = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      logic ret_i;
      ret_i = sl_v[i] && r_end && (sl_id[i] == rid);
      if (ret_i && !ret_hit) begin
        ret_hit = 1'b1;
        ret_idx = SW'(i);
      end
      if (sl_v[i] && !ret_i && (sl_age[i] >= thr_eff) && !hit) begin
        hit = 1'b1;
        hit_idx = SW'(i);
      end
      if (sl_v[i] && !ret_i && (sl_id[i] == arid)) dup = 1'b1;
      if (!sl_v[i] && !free_ok) begin
        free_ok = 1'b1;
        free_idx = SW'(i);
      end
    end
  end

  assign trigger  = armed && hit;
  assign rec_push = armed && !hit && ret_hit;
  assign alloc    = armed && !hit && ar_hs && free_ok && !dup;
  assign push     = rec_push || trigger;
  assign w_idx    = hit ? hit_idx : ret_idx;

  assign cnt_nx   = (cnt == CW'(DEPTH)) ? cnt : cnt + 1'b1;
  assign wp_inc   = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
  assign rp_inc   = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
  assign rp_start = PW'((int'(wp) + DEPTH + 1 - int'(cnt_nx)) % DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      wp   <= '0;
      cnt  <= '0;
      rp   <= '0;
      left <= '0;
      for (int i = 0; i < SLOTS; i++) sl_v[i] <= 1'b0;
    end else if (!enable) begin
      st  <= S_IDLE;
      wp  <= '0;
      cnt <= '0;
      for (int i = 0; i < SLOTS; i++) sl_v[i] <= 1'b0;
    end else begin
      case (st)
        S_IDLE: st <= S_ARMED;
        S_ARMED: begin
          for (int i = 0; i < SLOTS; i++) begin
            if (alloc && free_idx == SW'(i)) sl_v[i] <= 1'b1;
            else if (rec_push && ret_idx == SW'(i)) sl_v[i] <= 1'b0;
          end
          if (push) begin
            wp  <= wp_inc;
            cnt <= cnt_nx;
          end
          if (trigger) begin
            st   <= S_DUMP;
            rp   <= rp_start;
            left <= cnt_nx;
          end
        end
        S_DUMP: if (trc_ready) begin
          rp   <= rp_inc;
          left <= left - 1'b1;
          if (left == CW'(1)) st <= S_DONE;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (alloc && free_idx == SW'(i)) begin
        sl_id[i]   <= arid;
        sl_addr[i] <= araddr;
        sl_age[i]  <= CNT_W'(1);
      end else if (armed && sl_v[i] && sl_age[i] != AGE_TOP) begin
        sl_age[i] <= sl_age[i] + 1'b1;
      end
    end
    if (push) begin
      rg_id[wp]   <= sl_id[w_idx];
      rg_addr[wp] <= sl_addr[w_idx];
      rg_lat[wp]  <= sl_age[w_idx];
      rg_hung[wp] <= hit;
    end
  end

  assign trc_valid = (st == S_DUMP);
  assign trc_id    = rg_id[rp];
  assign trc_addr  = rg_addr[rp];
  assign trc_lat   = rg_lat[rp];
  assign trc_hung  = rg_hung[rp];
endmodule

// File: rtl/axi_rd_hang_tracer_chk.sv
`timescale 1ns/1ps
module axi_rd_hang_tracer_chk #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              trigger,
  input logic              trc_valid,
  input logic              trc_ready,
  input logic [ID_W-1:0]   trc_id,
  input logic [ADDR_W-1:0] trc_addr,
  input logic [CNT_W-1:0]  trc_lat,
  input logic              trc_hung
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       seen <= 1'b0;
    else if (!enable) seen <= 1'b0;
    else if (trigger) seen <= 1'b1;

  p_trigger_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> enable);
  p_quiet_until_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid |-> seen);
  p_trigger_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> !trigger);
  p_dump_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> trc_valid);
  p_hung_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid && trc_ready && trc_hung |=> !trc_valid);
  p_record_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trc_valid && !trc_ready |=> trc_valid && $stable(trc_id) && $stable(trc_addr)
                                && $stable(trc_lat) && $stable(trc_hung));
endmodule

bind axi_rd_hang_tracer axi_rd_hang_tracer_chk #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .trigger(trigger),
  .trc_valid(trc_valid), .trc_ready(trc_ready), .trc_id(trc_id),
  .trc_addr(trc_addr), .trc_lat(trc_lat), .trc_hung(trc_hung)
);

// File: tb/tb_axi_rd_hang_tracer.sv
`timescale 1ns/1ps
module tb_axi_rd_hang_tracer;
  localparam int ID_W = 4, ADDR_W = 32, DEPTH = 4, SLOTS = 4, CNT_W = 15;

  logic clk = 0, rst_n = 0, enable = 0;
  logic [CNT_W-1:0] threshold = '0;
  logic arvalid = 0, arready = 0, rvalid = 0, rready = 0, rlast = 0, trc_ready = 1;
  logic [ID_W-1:0] arid = '0, rid = '0;
  logic [ADDR_W-1:0] araddr = '0;
  logic trc_valid, trc_hung, trigger;
  logic [ID_W-1:0] trc_id;
  logic [ADDR_W-1:0] trc_addr;
  logic [CNT_W-1:0] trc_lat;

  axi_rd_hang_tracer #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .SLOTS(SLOTS),
                       .CNT_W(CNT_W), .MAX_TH(16384)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .threshold(threshold),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rlast(rlast),
    .trc_valid(trc_valid), .trc_ready(trc_ready), .trc_id(trc_id),
    .trc_addr(trc_addr), .trc_lat(trc_lat), .trc_hung(trc_hung), .trigger(trigger));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int trig_cnt = 0, vld_cnt = 0;
  int ncap = 0, trig_at = 0;
  logic [ID_W-1:0]   cap_id   [16];
  logic [ADDR_W-1:0] cap_addr [16];
  logic [CNT_W-1:0]  cap_lat  [16];
  logic              cap_hung [16];

  // {id[4], addr[32], latency[16], stall[8]}
  localparam int NV = 8;
  localparam logic [59:0] VEC [NV] = '{
    {4'd1, 32'h0000_1000, 16'd1, 8'd0},
    {4'd2, 32'h0000_2040, 16'd3, 8'd1},
    {4'd3, 32'h0000_3080, 16'd5, 8'd4},
    {4'd4, 32'h0000_40C0, 16'd2, 8'd0},
    {4'd5, 32'h0000_5100, 16'd7, 8'd3},
    {4'd6, 32'h0000_6140, 16'd4, 8'd2},
    {4'd7, 32'h0000_7180, 16'd1, 8'd0},
    {4'd8, 32'h0000_81C0, 16'd9, 8'd6}
  };

  always @(negedge clk) begin
    if (trigger) trig_cnt++;
    if (trc_valid) vld_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ar_issue(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a);
    arvalid = 1; arready = 1; arid = id; araddr = a;
    @(negedge clk);
    arvalid = 0; arready = 0;
  endtask

  task automatic r_done(input logic [ID_W-1:0] id);
    rvalid = 1; rready = 1; rlast = 1; rid = id;
    @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
  endtask

  task automatic do_read(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                         input int lat, input int stall);
    ar_issue(id, a);
    repeat (lat - 1 - stall) @(negedge clk);
    rvalid = 1; rlast = 1; rid = id; rready = 0;
    repeat (stall) @(negedge clk);
    rready = 1;
    @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
  endtask

  task automatic watch(input int n);
    for (int c = 1; c <= n; c++) begin
      if (trigger && trig_at == 0) trig_at = c;
      if (trc_valid && trc_ready && ncap < 16) begin
        cap_id[ncap] = trc_id; cap_addr[ncap] = trc_addr;
        cap_lat[ncap] = trc_lat; cap_hung[ncap] = trc_hung;
        ncap++;
      end
      @(negedge clk);
    end
  endtask

  task automatic rearm();
    enable = 0;
    repeat (2) @(negedge clk);
    enable = 1;
    repeat (2) @(negedge clk);
    ncap = 0; trig_at = 0;
  endtask

  initial begin
    #700us;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tc, vc;
    repeat (4) @(negedge clk);
    chk(trc_valid === 0 && trigger === 0, "R1", "outputs in reset",
        {trc_valid, trigger}, 0);
    rst_n = 1;
    threshold = 3;
    @(negedge clk);
    arvalid = 1; arready = 1; arid = 4'hC; araddr = 32'hC00;
    @(negedge clk);
    arvalid = 0; arready = 0;
    rvalid = 1; rid = 4'hC; rlast = 1;
    repeat (10) @(negedge clk);
    rvalid = 0; rlast = 0;
    chk(trig_cnt == 0 && vld_cnt == 0, "R1", "activity while disabled",
        trig_cnt + vld_cnt, 0);

    // Phase A: table walk, then hang with a held rvalid
    threshold = 30;
    enable = 1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      do_read(VEC[v][59:56], VEC[v][55:24], int'(VEC[v][23:8]), int'(VEC[v][7:0]));
      @(negedge clk);
    end
    chk(trig_cnt == 0, "R3", "trigger during normal reads", trig_cnt, 0);
    chk(vld_cnt == 0, "R3", "trace before trigger", vld_cnt, 0);

    trc_ready = 0;
    ar_issue(4'd9, 32'h0000_9000);
    rvalid = 1; rid = 4'd9; rlast = 1; rready = 0;
    trig_at = 0;
    watch(40);
    rvalid = 0; rlast = 0;
    chk(trig_at == 30, "R4", "trigger cycle for threshold 30", trig_at, 30);
    chk(trig_cnt == 1, "R4", "trigger pulse count", trig_cnt, 1);
    chk(trc_valid === 1, "R5", "dump pending", trc_valid, 1);
    begin
      logic [ADDR_W-1:0] a0;
      a0 = trc_addr;
      repeat (3) @(negedge clk);
      chk(trc_valid === 1 && trc_addr == a0, "R9", "record held while stalled",
          trc_addr, a0);
    end
    trc_ready = 1;
    ncap = 0;
    watch(8);
    chk(ncap == 4, "R5", "records dumped", ncap, 4);
    for (int k = 0; k < 3; k++) begin
      chk(cap_id[k] == VEC[5+k][59:56], "R6", "dump id", cap_id[k], VEC[5+k][59:56]);
      chk(cap_addr[k] == VEC[5+k][55:24], "R6", "dump addr", cap_addr[k], VEC[5+k][55:24]);
      chk(cap_lat[k] == CNT_W'(VEC[5+k][23:8]), "R2", "completed latency",
          cap_lat[k], VEC[5+k][23:8]);
      chk(cap_hung[k] == 0, "R5", "hung flag on history", cap_hung[k], 0);
    end
    chk(cap_id[3] == 4'd9 && cap_addr[3] == 32'h9000, "R5", "last record is stalled read",
        cap_addr[3], 32'h9000);
    chk(cap_lat[3] == 30 && cap_hung[3] == 1, "R2", "stalled latency and flag",
        {cap_hung[3], cap_lat[3]}, {1'b1, 15'd30});

    // Done state: new hang ignored
    tc = trig_cnt; vc = vld_cnt;
    ar_issue(4'd10, 32'h0000_A000);
    rvalid = 1; rid = 4'd10; rlast = 1;
    repeat (50) @(negedge clk);
    rvalid = 0; rlast = 0;
    chk(trig_cnt == tc && vld_cnt == vc, "R10", "silent in done state",
        (trig_cnt - tc) + (vld_cnt - vc), 0);

    // Phase B: full table, duplicate ID, first expiry wins
    rearm();
    threshold = 60;
    tc = trig_cnt;
    for (int i = 1; i <= 4; i++) ar_issue(ID_W'(i), ADDR_W'(i * 'h100));
    ar_issue(4'd5, 32'h500);
    r_done(4'd5);
    for (int i = 1; i <= 4; i++) r_done(ID_W'(i));
    ar_issue(4'd2, 32'hA20);
    ar_issue(4'd2, 32'hB20);
    r_done(4'd2);
    r_done(4'd2);
    ar_issue(4'd6, 32'h600);
    @(negedge clk);
    ar_issue(4'd7, 32'h700);
    watch(120);
    chk(trig_cnt - tc == 1, "R8", "single trigger with two expiries", trig_cnt - tc, 1);
    chk(ncap == 4, "R7", "records with untracked reads", ncap, 4);
    chk(cap_id[0] == 3 && cap_addr[0] == 32'h300, "R7", "record 0", cap_addr[0], 32'h300);
    chk(cap_id[1] == 4 && cap_addr[1] == 32'h400, "R7", "record 1", cap_addr[1], 32'h400);
    chk(cap_id[2] == 2 && cap_addr[2] == 32'hA20, "R7", "duplicate-ID record", cap_addr[2], 32'hA20);
    chk(cap_id[3] == 6 && cap_hung[3] == 1, "R8", "first expiry wins", cap_id[3], 6);
    chk(cap_lat[3] == 60, "R5", "stalled latency", cap_lat[3], 60);

    // Phase C: clamp and history cleared by re-arm
    rearm();
    threshold = 20000;
    ar_issue(4'd11, 32'h0000_B000);
    rvalid = 1; rid = 4'd11; rlast = 1;
    watch(16400);
    rvalid = 0; rlast = 0;
    chk(trig_at == 16384, "R4", "clamped trigger cycle", trig_at, 16384);
    chk(ncap == 1, "R10", "history cleared by re-arm", ncap, 1);
    chk(cap_id[0] == 11 && cap_lat[0] == 16384 && cap_hung[0] == 1, "R4",
        "clamped stalled record", cap_lat[0], 16384);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule